// File: doc/BRIEF.md
# Smart Panel Command Sequencer

This block runs a stream of 16-bit command words against a command-mode display panel attached to an 8080-style parallel bus. That bus has an active-low chip select, a register/data select line (A0), active-low write and read strobes, and an 8-bit data path. Here the data path is split into an output byte with an output enable and a separate input byte. Command words arrive two to a 32-bit word on a valid/ready input, and the lower half of each word runs first. Each command carries a 3-bit opcode, the A0 level and a data byte.

The opcodes cover writing a command or data byte, streaming frame bytes from a separate pixel valid/ready input, reading a byte back from the panel, waiting for a vsync edge, raising a sticky interrupt flag, and doing nothing. The bus timing comes from five cycle counts supplied as inputs: setup, strobe pulse, hold after a write, output hold after a read, and the inhibit gap after a write. After a read the sequencer stalls until software reports both status-OK and continue. A stop input returns the sequencer to idle at any time.

Top module: `spnl_seq`

## Requirements
- R1: A command word is decoded as follows. Bits 11:9 hold the opcode, bit 8 holds the A0 level and bits 7:0 hold the byte. Opcode 1 performs one bus write of that byte with A0 at bit 8's level. In a 32-bit input word, bits 15:0 run before bits 31:16.
- R2: Every bus cycle behaves like this. csN falls. After `cfgSetup` cycles the strobe falls and stays low for `cfgPulse` cycles. csN then stays low for a further `cfgHold` cycles after a write. Between two writes of the same input word, csN stays high for exactly `cfgInhibit`+1 cycles. A count of 0 acts as 1.
- R3: `dbOe` is high only while `wrN` is low. The two strobes are never low together. After reset csN, wrN and rdN are high and `dbOe` is low.
- R4: Opcode 0 performs one read. `rdN` is low for `cfgPulse` cycles. `dbIn` is captured into `rdData` on the last strobe cycle, and bit 8 of the command is captured into `rdA0`. csN then stays low for `cfgOpHold` cycles.
- R5: After a read, no further command runs until `rdOk` and `rdContinue` are both high.
- R6: Opcode 3 stalls the sequence until a rising edge of `vsyncIn`. A level that is already high does not release it.
- R7: Opcode 5 sets `intFlag`, which stays set until `intClr` is high. If a set and a clear fall in the same cycle, the set wins.
- R8: Opcodes 4, 6 and 7 cause no bus activity. So does opcode 2 with A0=0, and so does any command with bits 15:12 not zero.
- R9: Opcode 2 with A0=1 takes one byte from the pixel stream and writes it with A0=1. It repeats until it has written the byte that carried `pixLast`. After that, no more pixel bytes are taken.
- R10: A `stopReq` pulse makes `busy` low on the next cycle and discards the rest of the current input word. If it arrives in the same cycle as a vsync edge, the stop wins.
- R11: After reset the sequencer is idle: `busy`=0, `cmdReady`=1 and `intFlag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command word pair valid |
| cmdReady | output | 1 | Sequencer accepts a word pair |
| cmdWord | input | 32 | Two commands, lower half first |
| pixValid | input | 1 | Pixel byte valid |
| pixReady | output | 1 | Sequencer takes a pixel byte |
| pixData | input | 8 | Pixel byte |
| pixLast | input | 1 | Last byte of the frame |
| cfgSetup | input | CNT_W | Setup cycles before a strobe |
| cfgPulse | input | CNT_W | Strobe low cycles |
| cfgHold | input | CNT_W | csN low cycles after a write strobe |
| cfgOpHold | input | CNT_W | csN low cycles after a read strobe |
| cfgInhibit | input | CNT_W | csN high cycles after a write |
| vsyncIn | input | 1 | Panel vsync |
| stopReq | input | 1 | Abort and return to idle |
| rdOk | input | 1 | Software status-OK |
| rdContinue | input | 1 | Software continue |
| intClr | input | 1 | Clear the interrupt flag |
| intFlag | output | 1 | Sticky interrupt flag |
| rdData | output | 8 | Last byte read |
| rdA0 | output | 1 | A0 level of the last read |
| busy | output | 1 | Sequencer not idle |
| csN | output | 1 | Chip select, active low |
| a0 | output | 1 | Register/data select |
| wrN | output | 1 | Write strobe, active low |
| rdN | output | 1 | Read strobe, active low |
| dbOut | output | 8 | Byte driven onto the bus |
| dbOe | output | 1 | Drive enable for dbOut |
| dbIn | input | 8 | Byte read from the bus |

## Verification
Two pairs of events can land on the same clock edge. The first pair is an interrupt opcode setting the flag while `intClr` is held high. The bench keeps `intClr` high through a whole interrupt command and counts the sampled cycles with `intFlag` high. Exactly one such cycle shows that the set won and the clear then took effect. The second pair is `stopReq` and a rising `vsyncIn` edge while a vsync wait is pending. Both are driven on the same edge. The stop is judged to have won if `busy` drops and the write queued behind the wait never reaches the bus.

// File: rtl/spnl_pkg.sv
package spnl_pkg;
  localparam int CMD_W   = 16;
  localparam int PAIR_W  = 2 * CMD_W;
  localparam int BYTE_W  = 8;
  localparam int OP_LSB  = 9;
  localparam int OP_W    = 3;
  localparam int A0_BIT  = 8;
  localparam int RSV_LSB = OP_LSB + OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_FRAME = 3'd2,
    OP_VSYNC = 3'd3,
    OP_NOP   = 3'd4,
    OP_INT   = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } opcode_t;

  typedef enum logic [2:0] {
    TSEL_SETUP,
    TSEL_PULSE,
    TSEL_HOLD,
    TSEL_OPHOLD,
    TSEL_INHIB
  } tsel_t;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_SETUP,
    ST_PULSE,
    ST_POST,
    ST_INHIB,
    ST_RDWAIT,
    ST_VSWAIT,
    ST_PIXGET
  } seqState_t;

  typedef struct packed {
    logic  loadWord;
    logic  advHalf;
    logic  loadCnt;
    tsel_t cntSel;
    logic  loadPix;
    logic  capRead;
    logic  setInt;
    logic  busCs;
    logic  busWr;
    logic  busRd;
    logic  busDrive;
  } seqCtl_t;
endpackage

// File: rtl/spnl_dp.sv
module spnl_dp
  import spnl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [PAIR_W-1:0] cmdWord,
  input  logic [BYTE_W-1:0] pixData,
  input  logic              pixLast,
  input  logic [BYTE_W-1:0] dbIn,
  input  logic [CNT_W-1:0]  cfgSetup,
  input  logic [CNT_W-1:0]  cfgPulse,
  input  logic [CNT_W-1:0]  cfgHold,
  input  logic [CNT_W-1:0]  cfgOpHold,
  input  logic [CNT_W-1:0]  cfgInhibit,
  input  logic              intClr,
  output opcode_t           curOp,
  output logic              curA0,
  output logic              curRsvZero,
  output logic              halfHi,
  output logic              cntZero,
  output logic              frameLast,
  output logic              csN,
  output logic              a0,
  output logic              wrN,
  output logic              rdN,
  output logic [BYTE_W-1:0] dbOut,
  output logic              dbOe,
  output logic [BYTE_W-1:0] rdData,
  output logic              rdA0,
  output logic              intFlag
);
  localparam int RSV_W = CMD_W - RSV_LSB;

  logic [PAIR_W-1:0] wordReg;
  logic [CMD_W-1:0]  curHalf;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  selCfg;
  logic [CNT_W-1:0]  loadVal;
  logic [BYTE_W-1:0] pixByte;

  assign curHalf    = halfHi ? wordReg[PAIR_W-1:CMD_W] : wordReg[CMD_W-1:0];
  assign curOp      = opcode_t'(curHalf[OP_LSB +: OP_W]);
  assign curA0      = curHalf[A0_BIT];
  assign curRsvZero = (curHalf[RSV_LSB +: RSV_W] == '0);
  assign cntZero    = (cnt == '0);

  // Phase length selection; a zero count still yields one cycle
  always_comb begin
    case (ctl.cntSel)
      TSEL_SETUP:  selCfg = cfgSetup;
      TSEL_PULSE:  selCfg = cfgPulse;
      TSEL_HOLD:   selCfg = cfgHold;
      TSEL_OPHOLD: selCfg = cfgOpHold;
      default:     selCfg = cfgInhibit;
    endcase
    loadVal = (selCfg == '0) ? '0 : selCfg - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg <= '0;
      halfHi  <= 1'b0;
    end else if (ctl.loadWord) begin
      wordReg <= cmdWord;
      halfHi  <= 1'b0;
    end else if (ctl.advHalf) begin
      halfHi  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (ctl.loadCnt) cnt <= loadVal;
    else if (!cntZero)    cnt <= cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixByte   <= '0;
      frameLast <= 1'b0;
    end else if (ctl.loadPix) begin
      pixByte   <= pixData;
      frameLast <= pixLast;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      rdA0   <= 1'b0;
    end else if (ctl.capRead) begin
      rdData <= dbIn;
      rdA0   <= curA0;
    end
  end

  // Set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           intFlag <= 1'b0;
    else if (ctl.setInt) intFlag <= 1'b1;
    else if (intClr)     intFlag <= 1'b0;
  end

  assign csN   = ~ctl.busCs;
  assign a0    = ctl.busCs & curA0;
  assign wrN   = ~ctl.busWr;
  assign rdN   = ~ctl.busRd;
  assign dbOe  = ctl.busDrive;
  assign dbOut = (curOp == OP_FRAME) ? pixByte : curHalf[BYTE_W-1:0];
endmodule

// File: rtl/spnl_ctl.sv
module spnl_ctl
  import spnl_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  logic    pixValid,
  input  logic    stopReq,
  input  logic    vsyncIn,
  input  logic    rdOk,
  input  logic    rdContinue,
  input  opcode_t curOp,
  input  logic    curA0,
  input  logic    curRsvZero,
  input  logic    halfHi,
  input  logic    cntZero,
  input  logic    frameLast,
  output seqCtl_t ctl,
  output logic    cmdReady,
  output logic    pixReady,
  output logic    busy
);
  seqState_t state, nxt;
  logic      vsPrev;
  logic      vsEdge;
  logic      cmdDone;
  logic      isRead;
  opcode_t   effOp;

  assign vsEdge = vsyncIn & ~vsPrev;
  assign isRead = (curOp == OP_READ);
  assign effOp  = curRsvZero ? curOp : OP_NOP;
  assign busy   = (state != ST_FETCH);

  always_comb begin
    nxt      = state;
    ctl      = '0;
    cmdDone  = 1'b0;
    cmdReady = 1'b0;
    pixReady = 1'b0;
    case (state)
      ST_FETCH: begin
        cmdReady = 1'b1;
        if (cmdValid) begin
          ctl.loadWord = 1'b1;
          nxt          = ST_DECODE;
        end
      end
      ST_DECODE: begin
        case (effOp)
          OP_READ, OP_WRITE: begin
            ctl.loadCnt = 1'b1;
            ctl.cntSel  = TSEL_SETUP;
            nxt         = ST_SETUP;
          end
          OP_FRAME: begin
            if (curA0) nxt = ST_PIXGET;
            else       cmdDone = 1'b1;
          end
          OP_VSYNC: nxt = ST_VSWAIT;
          OP_INT: begin
            ctl.setInt = 1'b1;
            cmdDone    = 1'b1;
          end
          default: cmdDone = 1'b1;
        endcase
      end
      ST_SETUP: begin
        ctl.busCs = 1'b1;
        if (cntZero) begin
          ctl.loadCnt = 1'b1;
          ctl.cntSel  = TSEL_PULSE;
          nxt         = ST_PULSE;
        end
      end
      ST_PULSE: begin
        ctl.busCs = 1'b1;
        if (isRead) begin
          ctl.busRd = 1'b1;
        end else begin
          ctl.busWr    = 1'b1;
          ctl.busDrive = 1'b1;
        end
        if (cntZero) begin
          ctl.loadCnt = 1'b1;
          ctl.capRead = isRead;
          ctl.cntSel  = isRead ? TSEL_OPHOLD : TSEL_HOLD;
          nxt         = ST_POST;
        end
      end
      ST_POST: begin
        ctl.busCs = 1'b1;
        if (cntZero) begin
          if (isRead) begin
            nxt = ST_RDWAIT;
          end else begin
            ctl.loadCnt = 1'b1;
            ctl.cntSel  = TSEL_INHIB;
            nxt         = ST_INHIB;
          end
        end
      end
      ST_INHIB: begin
        if (cntZero) begin
          if (curOp == OP_FRAME && !frameLast) nxt = ST_PIXGET;
          else                                 cmdDone = 1'b1;
        end
      end
      ST_RDWAIT: begin
        if (rdOk && rdContinue) cmdDone = 1'b1;
      end
      ST_VSWAIT: begin
        if (vsEdge) cmdDone = 1'b1;
      end
      ST_PIXGET: begin
        pixReady = 1'b1;
        if (pixValid) begin
          ctl.loadPix = 1'b1;
          ctl.loadCnt = 1'b1;
          ctl.cntSel  = TSEL_SETUP;
          nxt         = ST_SETUP;
        end
      end
      default: nxt = ST_FETCH;
    endcase

    if (cmdDone) begin
      if (halfHi) begin
        nxt = ST_FETCH;
      end else begin
        ctl.advHalf = 1'b1;
        nxt         = ST_DECODE;
      end
    end

    // Stop overrides everything else in the same cycle
    if (stopReq) begin
      nxt      = ST_FETCH;
      ctl      = '0;
      cmdReady = 1'b0;
      pixReady = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_FETCH;
      vsPrev <= 1'b0;
    end else begin
      state  <= nxt;
      vsPrev <= vsyncIn;
    end
  end
endmodule

// File: rtl/spnl_seq.sv
module spnl_seq
  import spnl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [PAIR_W-1:0] cmdWord,
  input  logic              pixValid,
  output logic              pixReady,
  input  logic [BYTE_W-1:0] pixData,
  input  logic              pixLast,
  input  logic [CNT_W-1:0]  cfgSetup,
  input  logic [CNT_W-1:0]  cfgPulse,
  input  logic [CNT_W-1:0]  cfgHold,
  input  logic [CNT_W-1:0]  cfgOpHold,
  input  logic [CNT_W-1:0]  cfgInhibit,
  input  logic              vsyncIn,
  input  logic              stopReq,
  input  logic              rdOk,
  input  logic              rdContinue,
  input  logic              intClr,
  output logic              intFlag,
  output logic [BYTE_W-1:0] rdData,
  output logic              rdA0,
  output logic              busy,
  output logic              csN,
  output logic              a0,
  output logic              wrN,
  output logic              rdN,
  output logic [BYTE_W-1:0] dbOut,
  output logic              dbOe,
  input  logic [BYTE_W-1:0] dbIn
);
  seqCtl_t ctl;
  opcode_t curOp;
  logic    curA0;
  logic    curRsvZero;
  logic    halfHi;
  logic    cntZero;
  logic    frameLast;

  spnl_ctl ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .pixValid   (pixValid),
    .stopReq    (stopReq),
    .vsyncIn    (vsyncIn),
    .rdOk       (rdOk),
    .rdContinue (rdContinue),
    .curOp      (curOp),
    .curA0      (curA0),
    .curRsvZero (curRsvZero),
    .halfHi     (halfHi),
    .cntZero    (cntZero),
    .frameLast  (frameLast),
    .ctl        (ctl),
    .cmdReady   (cmdReady),
    .pixReady   (pixReady),
    .busy       (busy)
  );

  spnl_dp #(.CNT_W(CNT_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cmdWord    (cmdWord),
    .pixData    (pixData),
    .pixLast    (pixLast),
    .dbIn       (dbIn),
    .cfgSetup   (cfgSetup),
    .cfgPulse   (cfgPulse),
    .cfgHold    (cfgHold),
    .cfgOpHold  (cfgOpHold),
    .cfgInhibit (cfgInhibit),
    .intClr     (intClr),
    .curOp      (curOp),
    .curA0      (curA0),
    .curRsvZero (curRsvZero),
    .halfHi     (halfHi),
    .cntZero    (cntZero),
    .frameLast  (frameLast),
    .csN        (csN),
    .a0         (a0),
    .wrN        (wrN),
    .rdN        (rdN),
    .dbOut      (dbOut),
    .dbOe       (dbOe),
    .rdData     (rdData),
    .rdA0       (rdA0),
    .intFlag    (intFlag)
  );
endmodule

// File: rtl/spnl_seq_chk.sv
module spnl_seq_chk (
  input logic clk,
  input logic rstN,
  input logic cmdReady,
  input logic pixReady,
  input logic stopReq,
  input logic intClr,
  input logic intFlag,
  input logic busy,
  input logic csN,
  input logic wrN,
  input logic rdN,
  input logic dbOe
);
  p_oe_in_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    dbOe |-> (!wrN && !csN));

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> rdN);

  p_strobe_cs_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN || !rdN) |-> !csN);

  p_setup_before_wr_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrN) |-> $past(!csN));

  p_int_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (intFlag && !intClr) |=> intFlag);

  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !busy);

  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (!busy && csN));

  p_pix_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    pixReady |-> csN);
endmodule

bind spnl_seq spnl_seq_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .cmdReady (cmdReady),
  .pixReady (pixReady),
  .stopReq  (stopReq),
  .intClr   (intClr),
  .intFlag  (intFlag),
  .busy     (busy),
  .csN      (csN),
  .wrN      (wrN),
  .rdN      (rdN),
  .dbOe     (dbOe)
);

// File: tb/spnl_seq_tb_top.sv
module spnl_seq_tb_top;
  localparam int CW = 8;
  localparam int S_CY = 2, P_CY = 3, H_CY = 1, OH_CY = 3, I_CY = 2;
  localparam int NVEC = 8;
  localparam logic [31:0] VEC_WORD [NVEC] = '{
    32'h0381_0236, 32'h0800_02C5, 32'h03FF_0800, 32'h0E00_0C00,
    32'h0400_0800, 32'h0200_0300, 32'h02A5_035A, 32'h1255_0800 };
  localparam int VEC_EXP [NVEC] = '{2, 1, 1, 0, 0, 2, 2, 0};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, cmdValid, cmdReady, pixValid, pixReady, pixLast;
  logic [31:0] cmdWord;
  logic [7:0] pixData, rdData, dbOut, dbIn;
  logic [CW-1:0] cfgSetup, cfgPulse, cfgHold, cfgOpHold, cfgInhibit;
  logic vsyncIn, stopReq, rdOk, rdContinue, intClr, intFlag, rdA0, busy;
  logic csN, a0, wrN, rdN, dbOe;

  spnl_seq #(.CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdWord(cmdWord), .pixValid(pixValid), .pixReady(pixReady),
    .pixData(pixData), .pixLast(pixLast), .cfgSetup(cfgSetup),
    .cfgPulse(cfgPulse), .cfgHold(cfgHold), .cfgOpHold(cfgOpHold),
    .cfgInhibit(cfgInhibit), .vsyncIn(vsyncIn), .stopReq(stopReq),
    .rdOk(rdOk), .rdContinue(rdContinue), .intClr(intClr),
    .intFlag(intFlag), .rdData(rdData), .rdA0(rdA0), .busy(busy),
    .csN(csN), .a0(a0), .wrN(wrN), .rdN(rdN), .dbOut(dbOut),
    .dbOe(dbOe), .dbIn(dbIn));

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Bus monitor, sampled on the falling edge
  int evA0 [64], evData [64], evRd [64], evWidth [64], evSetup [64], evHold [64], evGap [64];
  int evCount = 0;
  int setupRun = 0, strobeRun = 0, postRun = 0, gapRun = 0;
  logic csPrev = 1'b1;
  int busViol = 0;
  int intHigh = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      csPrev = 1'b1; setupRun = 0; strobeRun = 0; postRun = 0; gapRun = 0;
    end else begin
      if (dbOe && wrN) busViol++;
      if (!wrN && !rdN) busViol++;
      if (intFlag) intHigh++;
      if (!csN && csPrev) begin
        if (evCount < 64) evGap[evCount] = gapRun;
        setupRun = 0; strobeRun = 0; postRun = 0;
      end
      if (csN && !csPrev) begin
        if (evCount > 0) evHold[evCount-1] = postRun;
        gapRun = 0;
      end
      if (csN) gapRun++;
      else if (!wrN || !rdN) begin
        if (strobeRun == 0 && evCount < 64) begin
          evSetup[evCount] = setupRun;
          evA0[evCount] = int'(a0);
          evData[evCount] = int'(dbOut);
          evRd[evCount] = int'(!rdN);
        end
        strobeRun++;
      end else if (strobeRun == 0) setupRun++;
      else begin
        if (postRun == 0 && evCount < 64) begin
          evWidth[evCount] = strobeRun;
          evCount++;
        end
        postRun++;
      end
      csPrev = csN;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; errors++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendWord(input logic [31:0] w);
    cmdValid = 1'b1; cmdWord = w;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic pushPix(input logic [7:0] b, input logic last);
    pixValid = 1'b1; pixData = b; pixLast = last;
    while (!pixReady) @(negedge clk);
    @(negedge clk);
    pixValid = 1'b0; pixLast = 1'b0;
  endtask

  task automatic waitIdle(input string tag);
    int n;
    n = 0;
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " idle"}, int'(busy), 0);
  endtask

  task automatic checkWrite(input string tag, input int idx, input int expA0, input int expData);
    chk({tag, " a0"}, evA0[idx], expA0);
    chk({tag, " data"}, evData[idx], expData);
    chk({tag, " is write"}, evRd[idx], 0);
  endtask

  task automatic runVec(input int v);
    int base, k;
    logic [31:0] w;
    logic [15:0] c;
    w = VEC_WORD[v];
    base = evCount;
    sendWord(w);
    waitIdle("R1");
    chk($sformatf("R8 vec%0d event count", v), evCount - base, VEC_EXP[v]);
    k = base;
    for (int h = 0; h < 2; h++) begin
      c = (h == 0) ? w[15:0] : w[31:16];
      if (c[15:12] == 4'd0 && c[11:9] == 3'd1 && k < evCount) begin
        checkWrite($sformatf("R1 vec%0d half%0d", v, h), k, int'(c[8]), int'(c[7:0]));
        chk("R2 pulse width", evWidth[k], P_CY);
        chk("R2 setup", evSetup[k], S_CY);
        chk("R2 hold", evHold[k], H_CY);
        if (k > base) chk("R2 inhibit gap", evGap[k], I_CY + 1);
        k++;
      end
    end
  endtask

  initial begin
    int base;
    rstN = 1'b0; cmdValid = 1'b0; cmdWord = '0; pixValid = 1'b0; pixData = '0;
    pixLast = 1'b0; vsyncIn = 1'b0; stopReq = 1'b0; rdOk = 1'b0;
    rdContinue = 1'b0; intClr = 1'b0; dbIn = 8'h00;
    cfgSetup = CW'(S_CY); cfgPulse = CW'(P_CY); cfgHold = CW'(H_CY);
    cfgOpHold = CW'(OH_CY); cfgInhibit = CW'(I_CY);
    waitCycles(3);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 reset busy", int'(busy), 0);
    chk("R11 reset cmdReady", int'(cmdReady), 1);
    chk("R11 reset intFlag", int'(intFlag), 0);
    chk("R3 reset csN", int'(csN), 1);
    chk("R3 reset wrN", int'(wrN), 1);
    chk("R3 reset rdN", int'(rdN), 1);
    chk("R3 reset dbOe", int'(dbOe), 0);

    for (int v = 0; v < NVEC; v++) runVec(v);

    // Read stall until both status bits set
    dbIn = 8'h5A;
    base = evCount;
    sendWord(32'h02AB_0000);
    waitCycles(30);
    chk("R4 read events", evCount - base, 1);
    chk("R4 read strobe", evRd[base], 1);
    chk("R4 read width", evWidth[base], P_CY);
    chk("R4 read setup", evSetup[base], S_CY);
    chk("R4 read output hold", evHold[base], OH_CY);
    chk("R4 rdData", int'(rdData), 'h5A);
    chk("R4 rdA0", int'(rdA0), 0);
    chk("R5 stalled busy", int'(busy), 1);
    rdOk = 1'b1;
    waitCycles(10);
    chk("R5 ok alone holds", evCount - base, 1);
    rdContinue = 1'b1;
    waitIdle("R5");
    chk("R5 released count", evCount - base, 2);
    checkWrite("R5 after read", base + 1, 0, 'hAB);
    dbIn = 8'hC3;
    sendWord(32'h0800_0100);
    waitIdle("R4");
    chk("R4 frame read rdData", int'(rdData), 'hC3);
    chk("R4 frame read rdA0", int'(rdA0), 1);
    rdOk = 1'b0; rdContinue = 1'b0;

    // Vsync wait: a held level does not release
    vsyncIn = 1'b1;
    waitCycles(2);
    base = evCount;
    sendWord(32'h0255_0600);
    waitCycles(20);
    chk("R6 level high holds", evCount - base, 0);
    vsyncIn = 1'b0;
    waitCycles(2);
    vsyncIn = 1'b1;
    waitIdle("R6");
    chk("R6 edge releases", evCount - base, 1);
    checkWrite("R6 write after wait", base, 0, 'h55);

    // Stop colliding with a vsync edge
    vsyncIn = 1'b0;
    waitCycles(2);
    base = evCount;
    sendWord(32'h0277_0600);
    waitCycles(5);
    stopReq = 1'b1; vsyncIn = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    chk("R10 stop idle", int'(busy), 0);
    waitCycles(20);
    chk("R10 rest of word dropped", evCount - base, 0);
    sendWord(32'h0800_0266);
    waitIdle("R10");
    chk("R10 resumes", evCount - base, 1);
    checkWrite("R10 next word", base, 0, 'h66);

    // Interrupt flag
    sendWord(32'h0800_0A00);
    waitIdle("R7");
    chk("R7 flag set", int'(intFlag), 1);
    waitCycles(5);
    chk("R7 flag sticky", int'(intFlag), 1);
    intClr = 1'b1;
    @(negedge clk);
    intClr = 1'b0;
    chk("R7 flag cleared", int'(intFlag), 0);
    intHigh = 0;
    intClr = 1'b1;
    sendWord(32'h0800_0A00);
    waitIdle("R7");
    waitCycles(3);
    chk("R7 set wins over clear", intHigh, 1);
    chk("R7 cleared after", int'(intFlag), 0);
    intClr = 1'b0;

    // Frame write from pixel stream
    base = evCount;
    fork
      sendWord(32'h0800_0500);
      begin
        pushPix(8'h11, 1'b0);
        pushPix(8'h22, 1'b0);
        pushPix(8'h33, 1'b1);
      end
    join
    waitIdle("R9");
    chk("R9 frame events", evCount - base, 3);
    checkWrite("R9 byte0", base, 1, 'h11);
    checkWrite("R9 byte1", base + 1, 1, 'h22);
    checkWrite("R9 byte2", base + 2, 1, 'h33);
    chk("R9 frame gap", evGap[base + 1], I_CY + 1);
    pixValid = 1'b1; pixData = 8'h44;
    waitCycles(10);
    chk("R9 no take after last", int'(pixReady), 0);
    chk("R9 no extra write", evCount - base, 3);
    pixValid = 1'b0;

    // Zero count acts as one
    cfgPulse = '0;
    base = evCount;
    sendWord(32'h0800_0242);
    waitIdle("R2");
    chk("R2 zero pulse count", evWidth[base], 1);
    cfgPulse = CW'(P_CY);

    chk("R3 drive only in write pulse", busViol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule